// File: doc/BRIEF.md
# Adaptive Link Width Scaler

This block decides how many of the parallel coherency links between two nodes stay powered. It sees a per-cycle traffic flag for every link and adds up the busy cycles of the enabled links over a fixed power-of-two sampling window. At the end of each window, the total is compared with two thresholds set by software. Each threshold is given per link and is scaled by the number of enabled links.

A window above the upper threshold extends the scale-up streak. A window below the lower threshold extends the scale-down streak. Once a streak reaches its programmed dwell length, one link is added or removed. After every change the block holds for a fixed settling period. During that period it takes no measurement and raises a busy flag.

The enable mask is a thermometer code from bit 0. Links are therefore switched off from the top index downward and switched on again from the bottom upward.

Top module: `link_width_scaler`

## Requirements
- R1: After reset all NUM_LINKS links are enabled (link_en_o all ones) and busy_o is low.
- R2: link_en_o is always a thermometer code: bit i is set exactly when i < n, with the active count n between 1 and NUM_LINKS. Removing a link clears the highest set bit, and adding one sets the lowest clear bit.
- R3: In each window of 2**WIN_LOG2 cycles, the block sums link_busy_i over enabled links only; busy flags of disabled links have no effect. A window is high when sum > thr_hi_i*n and low when sum < thr_lo_i*n. Software keeps thr_lo_i < thr_hi_i.
- R4: When a high window brings the count of consecutive high windows to dwell_up_i, one link is added in the cycle after that window's last cycle, unless n is already NUM_LINKS. A dwell of 0 acts as 1.
- R5: When a low window brings the count of consecutive low windows to dwell_dn_i, one link is removed in the cycle after that window's last cycle, unless n is already 1. A dwell of 0 acts as 1.
- R6: A window that is not high clears the scale-up streak, and a window that is not low clears the scale-down streak. A step also clears its streak.
- R7: After each change, busy_o is high for exactly SETTLE_CYC cycles, starting in the cycle the new mask appears. Traffic during those cycles is ignored, and the next window starts when busy_o falls. The mask never changes while busy_o was high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| link_busy_i | input | NUM_LINKS | Per-link traffic-valid flag for this cycle |
| thr_hi_i | input | WIN_LOG2+1 | Upper threshold, busy cycles per link per window |
| thr_lo_i | input | WIN_LOG2+1 | Lower threshold, busy cycles per link per window |
| dwell_up_i | input | DWELL_W | High windows in a row needed to add a link |
| dwell_dn_i | input | DWELL_W | Low windows in a row needed to remove a link |
| link_en_o | output | NUM_LINKS | Per-link enable, thermometer from bit 0 |
| busy_o | output | 1 | Settling after a width change |

## Verification
The checker relies on software keeping the lower threshold strictly below the upper one. It also assumes the thresholds and dwell values are stable while a window is being measured. The stimulus sets them only before reset is released or at whole-phase boundaries, always with lower below upper.

Traffic runs through idle, saturated, random and alternating idle/full phases. These phases drive the width to both ends, break dwell streaks, and feed full traffic during settling, to confirm that the scaler ignores it.

// File: rtl/lws_pkg.sv
package lws_pkg;
  typedef enum logic [1:0] {
    DEC_HOLD = 2'd0,
    DEC_UP   = 2'd1,
    DEC_DN   = 2'd2
  } lws_dec_e;
endpackage

// File: rtl/lws_util_meter.sv
module lws_util_meter #(
  parameter int NUM_LINKS = 4,
  parameter int WIN_LOG2  = 4,
  parameter int ACC_W     = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hold_i,
  input  logic [NUM_LINKS-1:0] busy_i,
  input  logic [NUM_LINKS-1:0] en_i,
  output logic                 sample_o,
  output logic [ACC_W-1:0]     sum_o
);
  localparam logic [WIN_LOG2-1:0] WIN_LAST = '1;

  logic [WIN_LOG2-1:0] win_q;
  logic [ACC_W-1:0]    acc_q;
  logic [ACC_W-1:0]    inc;

  always_comb begin
    inc = '0;
    for (int i = 0; i < NUM_LINKS; i++) begin
      inc = inc + ACC_W'(busy_i[i] & en_i[i]);
    end
  end

  assign sample_o = !hold_i && (win_q == WIN_LAST);
  assign sum_o    = acc_q + inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      acc_q <= '0;
    end else if (hold_i || (win_q == WIN_LAST)) begin
      win_q <= '0;
      acc_q <= '0;
    end else begin
      win_q <= win_q + 1'b1;
      acc_q <= acc_q + inc;
    end
  end
endmodule

// File: rtl/lws_dwell_ctrl.sv
module lws_dwell_ctrl
  import lws_pkg::*;
#(
  parameter int NUM_LINKS = 4,
  parameter int WIN_LOG2  = 4,
  parameter int DWELL_W   = 8,
  parameter int ACC_W     = 7,
  parameter int CNT_W     = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_i,
  input  logic [ACC_W-1:0]    sum_i,
  input  logic [CNT_W-1:0]    n_i,
  input  logic [WIN_LOG2:0]   thr_hi_i,
  input  logic [WIN_LOG2:0]   thr_lo_i,
  input  logic [DWELL_W-1:0]  dwell_up_i,
  input  logic [DWELL_W-1:0]  dwell_dn_i,
  output lws_dec_e            dec_o
);
  localparam logic [CNT_W-1:0]   N_MAX = CNT_W'(NUM_LINKS);
  localparam logic [DWELL_W-1:0] D_MAX = '1;

  logic [DWELL_W-1:0] up_q, dn_q, up_inc, dn_inc, up_req, dn_req;
  logic [ACC_W-1:0]   hi_lim, lo_lim;
  logic               is_hi, is_lo;

  assign hi_lim = ACC_W'(thr_hi_i) * ACC_W'(n_i);
  assign lo_lim = ACC_W'(thr_lo_i) * ACC_W'(n_i);
  assign is_hi  = sum_i > hi_lim;
  assign is_lo  = sum_i < lo_lim;

  assign up_inc = (up_q == D_MAX) ? up_q : up_q + 1'b1;
  assign dn_inc = (dn_q == D_MAX) ? dn_q : dn_q + 1'b1;
  assign up_req = (dwell_up_i == '0) ? DWELL_W'(1) : dwell_up_i;
  assign dn_req = (dwell_dn_i == '0) ? DWELL_W'(1) : dwell_dn_i;

  always_comb begin
    dec_o = DEC_HOLD;
    if (sample_i) begin
      if (is_hi && (up_inc >= up_req) && (n_i < N_MAX))        dec_o = DEC_UP;
      else if (is_lo && (dn_inc >= dn_req) && (n_i > CNT_W'(1))) dec_o = DEC_DN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= '0;
      dn_q <= '0;
    end else if (sample_i) begin
      if (is_hi) begin
        up_q <= (dec_o == DEC_UP) ? '0 : up_inc;
        dn_q <= '0;
      end else if (is_lo) begin
        dn_q <= (dec_o == DEC_DN) ? '0 : dn_inc;
        up_q <= '0;
      end else begin
        up_q <= '0;
        dn_q <= '0;
      end
    end
  end
endmodule

// File: rtl/lws_width_reg.sv
module lws_width_reg
  import lws_pkg::*;
#(
  parameter int NUM_LINKS  = 4,
  parameter int SETTLE_CYC = 8,
  parameter int CNT_W      = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  lws_dec_e             dec_i,
  output logic [CNT_W-1:0]     n_o,
  output logic [NUM_LINKS-1:0] en_o,
  output logic                 busy_o
);
  localparam int ST_W = $clog2(SETTLE_CYC + 1);

  logic [ST_W-1:0]  settle_q;
  logic [CNT_W-1:0] n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q      <= CNT_W'(NUM_LINKS);
      settle_q <= '0;
    end else begin
      unique case (dec_i)
        DEC_UP: begin
          n_q      <= n_q + 1'b1;
          settle_q <= ST_W'(SETTLE_CYC);
        end
        DEC_DN: begin
          n_q      <= n_q - 1'b1;
          settle_q <= ST_W'(SETTLE_CYC);
        end
        default: if (settle_q != '0) settle_q <= settle_q - 1'b1;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_en
    assign en_o[g] = (CNT_W'(g) < n_q);
  end

  assign n_o    = n_q;
  assign busy_o = (settle_q != '0);
endmodule

// File: rtl/link_width_scaler.sv
module link_width_scaler
  import lws_pkg::*;
#(
  parameter int NUM_LINKS  = 4,
  parameter int WIN_LOG2   = 4,
  parameter int DWELL_W    = 8,
  parameter int SETTLE_CYC = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINKS-1:0] link_busy_i,
  input  logic [WIN_LOG2:0]    thr_hi_i,
  input  logic [WIN_LOG2:0]    thr_lo_i,
  input  logic [DWELL_W-1:0]   dwell_up_i,
  input  logic [DWELL_W-1:0]   dwell_dn_i,
  output logic [NUM_LINKS-1:0] link_en_o,
  output logic                 busy_o
);
  localparam int CNT_W = $clog2(NUM_LINKS + 1);
  localparam int ACC_W = WIN_LOG2 + CNT_W;

  logic             sample;
  logic [ACC_W-1:0] sum;
  logic [CNT_W-1:0] n_act;
  lws_dec_e         dec;

  lws_util_meter #(
    .NUM_LINKS(NUM_LINKS), .WIN_LOG2(WIN_LOG2), .ACC_W(ACC_W)
  ) u_meter (
    .clk_i, .rst_ni,
    .hold_i  (busy_o),
    .busy_i  (link_busy_i),
    .en_i    (link_en_o),
    .sample_o(sample),
    .sum_o   (sum)
  );

  lws_dwell_ctrl #(
    .NUM_LINKS(NUM_LINKS), .WIN_LOG2(WIN_LOG2), .DWELL_W(DWELL_W),
    .ACC_W(ACC_W), .CNT_W(CNT_W)
  ) u_dwell (
    .clk_i, .rst_ni,
    .sample_i  (sample),
    .sum_i     (sum),
    .n_i       (n_act),
    .thr_hi_i  (thr_hi_i),
    .thr_lo_i  (thr_lo_i),
    .dwell_up_i(dwell_up_i),
    .dwell_dn_i(dwell_dn_i),
    .dec_o     (dec)
  );

  lws_width_reg #(
    .NUM_LINKS(NUM_LINKS), .SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W)
  ) u_width (
    .clk_i, .rst_ni,
    .dec_i (dec),
    .n_o   (n_act),
    .en_o  (link_en_o),
    .busy_o(busy_o)
  );
endmodule

// File: rtl/lws_checker.sv
module lws_checker #(
  parameter int NUM_LINKS = 4,
  parameter int WIN_LOG2  = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [WIN_LOG2:0]    thr_hi_i,
  input logic [WIN_LOG2:0]    thr_lo_i,
  input logic [NUM_LINKS-1:0] link_en_o,
  input logic                 busy_o
);
  AST_THR_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_lo_i < thr_hi_i);  // R3

  AST_THERMO_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_en_o[0] && ((link_en_o & (link_en_o + 1'b1)) == '0));  // R2

  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(link_en_o ^ $past(link_en_o)) <= 1);  // R4

  AST_CHANGE_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_en_o != $past(link_en_o)) |-> busy_o);  // R7

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> $stable(link_en_o));  // R7
endmodule

bind link_width_scaler lws_checker #(
  .NUM_LINKS(NUM_LINKS), .WIN_LOG2(WIN_LOG2)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .thr_hi_i (thr_hi_i),
  .thr_lo_i (thr_lo_i),
  .link_en_o(link_en_o),
  .busy_o   (busy_o)
);

// File: tb/link_width_scaler_tb.sv
module link_width_scaler_tb;
  localparam int NL = 4;
  localparam int WL = 4;
  localparam int DW = 8;
  localparam int SC = 8;
  localparam int WIN = 1 << WL;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NL-1:0] link_busy_i = '0;
  logic [WL:0]   thr_hi_i = 5'd12;
  logic [WL:0]   thr_lo_i = 5'd4;
  logic [DW-1:0] dwell_up_i = 8'd3;
  logic [DW-1:0] dwell_dn_i = 8'd2;
  logic [NL-1:0] link_en_o;
  logic          busy_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk_i = ~clk_i;

  link_width_scaler #(.NUM_LINKS(NL), .WIN_LOG2(WL), .DWELL_W(DW), .SETTLE_CYC(SC)) u_dut (.*);

  // behavioural reference
  int m_n, m_settle, m_win, m_acc, m_up, m_dn;

  function automatic int mask_of(int n);
    return (1 << n) - 1;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_n = NL; m_settle = 0; m_win = 0; m_acc = 0; m_up = 0; m_dn = 0;
    end else if (m_settle > 0) begin
      m_settle--;
    end else begin
      for (int i = 0; i < m_n; i++) m_acc += link_busy_i[i];
      if (m_win == WIN - 1) begin
        int ureq, dreq;
        bit hi, lo;
        ureq = (dwell_up_i == 0) ? 1 : int'(dwell_up_i);
        dreq = (dwell_dn_i == 0) ? 1 : int'(dwell_dn_i);
        hi = m_acc > int'(thr_hi_i) * m_n;
        lo = m_acc < int'(thr_lo_i) * m_n;
        if (hi) begin
          m_dn = 0;
          if (m_up < 255) m_up++;
          if (m_up >= ureq && m_n < NL) begin m_n++; m_up = 0; m_settle = SC; end
        end else if (lo) begin
          m_up = 0;
          if (m_dn < 255) m_dn++;
          if (m_dn >= dreq && m_n > 1) begin m_n--; m_dn = 0; m_settle = SC; end
        end else begin
          m_up = 0; m_dn = 0;
        end
        m_win = 0; m_acc = 0;
      end else begin
        m_win++;
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk_i) if (rst_ni && !done) begin
    chk(link_en_o == NL'(mask_of(m_n)), "R2/R4/R5 mask", int'(link_en_o), mask_of(m_n));
    chk(busy_o == (m_settle > 0), "R7 busy", int'(busy_o), int'(m_settle > 0));
  end

  int mode = 0;  // 0 idle, 1 full, 2 random, 3 idle24/full24
  int phase_cnt = 0;
  always @(negedge clk_i) begin
    phase_cnt++;
    case (mode)
      0: link_busy_i <= '0;
      1: link_busy_i <= '1;
      2: link_busy_i <= NL'($urandom);
      default: link_busy_i <= ((phase_cnt % 48) < 24) ? '0 : '1;
    endcase
  end

  task automatic run(int cycles);
    repeat (cycles) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    run(3);
    chk(link_en_o == '1, "R1 reset mask", int'(link_en_o), 15);
    chk(busy_o == 1'b0, "R1 reset busy", int'(busy_o), 0);
    rst_ni = 1'b1;

    // R5: idle traffic walks the width down to the floor
    mode = 0; run(400);
    chk(link_en_o == 4'b0001, "R5 floor at one link", int'(link_en_o), 1);

    // R4: saturated traffic walks it back up to the ceiling
    mode = 1; run(400);
    chk(link_en_o == 4'b1111, "R4 ceiling at four links", int'(link_en_o), 15);

    // R6: alternating idle/full never builds a 4-window low streak
    dwell_dn_i = 8'd4; phase_cnt = 0; mode = 3; run(600);
    chk(link_en_o == 4'b1111, "R6 streak broken", int'(link_en_o), 15);

    // R7: first drop, then full traffic during settling is ignored
    dwell_dn_i = 8'd1; mode = 0;
    while (link_en_o == 4'b1111) @(negedge clk_i);
    mode = 1;
    begin
      int nb = 0;
      while (busy_o) begin
        nb++;
        chk(link_en_o == 4'b0111, "R7 mask held while busy", int'(link_en_o), 7);
        @(negedge clk_i);
      end
      chk(nb == SC, "R7 settle length", nb, SC);
    end

    // R3: random traffic, zero dwell acting as one
    dwell_up_i = 8'd0; dwell_dn_i = 8'd0; thr_hi_i = 5'd9; thr_lo_i = 5'd7;
    mode = 2; run(1500);

    // R3: disabled links' traffic ignored -- at one link, only link 0 busy counts
    thr_hi_i = 5'd12; thr_lo_i = 5'd4; dwell_dn_i = 8'd1; dwell_up_i = 8'd1;
    mode = 0; run(300);
    chk(link_en_o == 4'b0001, "R3 at one link", int'(link_en_o), 1);
    force link_busy_i = 4'b1110;
    run(200);
    chk(link_en_o == 4'b0001, "R3 disabled link traffic ignored", int'(link_en_o), 1);
    release link_busy_i;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule